// File: doc/BRIEF.md
# Eight-Level Cascadable Interrupt Controller

This block collects interrupt requests from eight lines and works out which one may interrupt the processor at the moment. It raises one request line towards the processor, takes the processor's two-pulse acknowledge and then returns a vector byte on its data output. The vector byte combines a programmable base with the number of the serviced line. A request register latches rising edges on the lines. A mask register holds requests back without losing them. An in-service register records which levels the processor is handling, so nesting follows a fixed priority.

Several controllers can be chained for more request levels. The master drives a 3-bit cascade code that names the level being acknowledged, but only when a slave controller is attached to that level. A slave returns its vector only when the cascade code matches its own programmed identity. A select pin chooses the role: 1 for master, 0 for slave.

The processor reaches the registers through a byte-wide port. The port has active-low chip select, read and write strobes and one address bit. All strobes are sampled on the block clock. There is no multi-word initialization sequence. Single command bytes set the vector base, the slave identity, the cascade map and the read source.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the request, in-service, mask and cascade-map registers are zero, the read source is the request register, and `int_out`, `dout_en` and `cas_oe` are low.
- R2: A rising edge on `irq[i]` sets request bit i whether or not bit i is masked. A read with `a0`=0 returns the request register when the read source is the request register (command `010xxxx0`) and the in-service register after command `010xxxx1`.
- R3: A write with `a0`=1 loads the mask (bit i set holds line i off), and a read with `a0`=1 returns it. A masked request keeps `int_out` low, and clearing the mask bit raises `int_out` on the next cycle.
- R4: Line 0 has the highest priority and line 7 the lowest. `int_out` is high exactly when some unmasked request exists and its highest-priority index is lower than the highest-priority in-service index, or when nothing is in service.
- R5: At the end of the first `inta_n` low pulse, the level chosen at its start moves from the request register to the in-service register.
- R6: While the second `inta_n` pulse is low, `dout_en` is high and `dout` = {base[4:0], level[2:0]}. The base is set by command `111bbbbb`.
- R7: The end-of-interrupt command `001xxxxx` clears only the lowest-index set in-service bit.
- R8: Cascade-map command `101hdddd` loads map bits [7:4] when h=1 and [3:0] when h=0. In master mode, while acknowledging a mapped level, `cas_oe`=1 and `cas_out` is the level, and no vector is driven.
- R9: In slave mode (`ms_sel`=0) `cas_oe` stays low, and the identity is set by command `110xxiii`. If `cas_in` differs from the identity at the end of the first pulse, the acknowledge leaves the registers unchanged and drives no vector. If it matches, the slave commits and drives its vector.
- R10: A register write takes effect once per falling edge of the combined strobe (`cs_n`=0 and `wr_n`=0), however long the strobe is held. With `cs_n`=1 no write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select of the register port |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a0 | input | 1 | Register address bit (1 = mask, 0 = command/status) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or vector byte |
| dout_en | output | 1 | High while `dout` carries valid data |
| irq | input | 8 | Request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta_n | input | 1 | Active-low acknowledge pulses from the processor |
| ms_sel | input | 1 | Role select: 1 master, 0 slave |
| cas_in | input | 3 | Cascade code seen by a slave |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | Enable for `cas_out` |

## Verification
A stale or wrong request or in-service bit shows up on `int_out` in the cycle after it forms. It also shows up on the next status read and on the level inside the next vector byte. A lost level choice in the acknowledge sequencer shows up within one pulse, either on `cas_out` or on the vector during the second pulse. The bench therefore runs a behavioural model beside the block and compares `int_out`, `dout`, `dout_en`, `cas_out` and `cas_oe` on every clock. It also makes directed register reads around masking, nesting, end-of-interrupt, strobe holding and both cascade roles.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_FIRST  = 2'd1,
        ACK_GAP    = 2'd2,
        ACK_SECOND = 2'd3
    } ack_state_e;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_EOI    = 3'b001;
    localparam logic [OP_W-1:0] OP_RDSEL  = 3'b010;
    localparam logic [OP_W-1:0] OP_CASMAP = 3'b101;
    localparam logic [OP_W-1:0] OP_IDENT  = 3'b110;
    localparam logic [OP_W-1:0] OP_BASE   = 3'b111;

endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);

    // lowest set index wins: walk from the top so lower indices overwrite
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pic_edge.sv
module pic_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lines;
        rise   = lines & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
    import pic_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inta_n,
    input  logic         req,
    input  logic [W-1:0] req_lvl,
    input  logic         ms_sel,
    input  logic [W-1:0] cas_in,
    input  logic [W-1:0] ident,
    output logic         in_ack,
    output logic         second,
    output logic [W-1:0] lvl,
    output logic         valid,
    output logic         matched,
    output logic         commit
);

    typedef struct packed {
        ack_state_e   st;
        logic [W-1:0] lvl;
        logic         valid;
        logic         matched;
    } ack_t;

    ack_t a_d, a_q;

    always_comb begin
        a_d    = a_q;
        commit = 1'b0;
        unique case (a_q.st)
            ACK_IDLE: begin
                if (!inta_n) begin
                    a_d.st    = ACK_FIRST;
                    a_d.valid = req;
                    a_d.lvl   = req ? req_lvl : {W{1'b1}};
                end
            end
            ACK_FIRST: begin
                if (inta_n) begin
                    a_d.st      = ACK_GAP;
                    a_d.matched = ms_sel || (cas_in == ident);
                    commit      = a_q.valid && a_d.matched;
                end
            end
            ACK_GAP: begin
                if (!inta_n) a_d.st = ACK_SECOND;
            end
            ACK_SECOND: begin
                if (inta_n) a_d.st = ACK_IDLE;
            end
            default: a_d.st = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q.st      <= ACK_IDLE;
            a_q.lvl     <= '0;
            a_q.valid   <= 1'b0;
            a_q.matched <= 1'b0;
        end else begin
            a_q <= a_d;
        end
    end

    always_comb begin
        in_ack  = (a_q.st != ACK_IDLE);
        second  = (a_q.st == ACK_SECOND);
        lvl     = a_q.lvl;
        valid   = a_q.valid;
        matched = a_q.matched;
    end

    AST_VEC_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        second |-> !$past(inta_n)); // R6

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic                       a0,
    input  logic [DATA_W-1:0]          din,
    output logic [DATA_W-1:0]          dout,
    output logic                       dout_en,
    input  logic [LINES-1:0]           irq,
    output logic                       int_out,
    input  logic                       inta_n,
    input  logic                       ms_sel,
    input  logic [$clog2(LINES)-1:0]   cas_in,
    output logic [$clog2(LINES)-1:0]   cas_out,
    output logic                       cas_oe
);

    localparam int LVL_W  = $clog2(LINES);
    localparam int BASE_W = DATA_W - LVL_W;
    localparam int HALF   = LINES / 2;

    typedef struct packed {
        logic [LINES-1:0]  irr;
        logic [LINES-1:0]  isr;
        logic [LINES-1:0]  mask;
        logic [LINES-1:0]  cmap;
        logic [BASE_W-1:0] base;
        logic [LVL_W-1:0]  ident;
        logic              rd_isr;
        logic              wr_seen;
    } regs_t;

    regs_t r_d, r_q;

    logic [LINES-1:0] rise;
    logic [LINES-1:0] pend;
    logic [LVL_W-1:0] pend_idx, isr_idx;
    logic             pend_any, isr_any;
    logic             int_req;
    logic             in_ack, second, ack_valid, ack_matched, commit;
    logic [LVL_W-1:0] ack_lvl;
    logic             wr_strobe, wr_act, eoi_act;
    logic [OP_W-1:0]  op;
    logic             rd_en, vec_en, map_hit;
    logic [DATA_W-1:0] rd_data;

    pic_edge #(.N(LINES)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq),
        .rise  (rise)
    );

    pic_prio #(.N(LINES), .W(LVL_W)) i_prio_pend (
        .vec (pend),
        .idx (pend_idx),
        .any (pend_any)
    );

    pic_prio #(.N(LINES), .W(LVL_W)) i_prio_isr (
        .vec (r_q.isr),
        .idx (isr_idx),
        .any (isr_any)
    );

    pic_ack_seq #(.W(LVL_W)) i_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .inta_n  (inta_n),
        .req     (int_req),
        .req_lvl (pend_idx),
        .ms_sel  (ms_sel),
        .cas_in  (cas_in),
        .ident   (r_q.ident),
        .in_ack  (in_ack),
        .second  (second),
        .lvl     (ack_lvl),
        .valid   (ack_valid),
        .matched (ack_matched),
        .commit  (commit)
    );

    // priority resolution against the level currently in service
    always_comb begin
        pend    = r_q.irr & ~r_q.mask;
        int_req = pend_any && (!isr_any || (pend_idx < isr_idx));
    end

    // register next-state
    always_comb begin
        r_d       = r_q;
        wr_strobe = !cs_n && !wr_n;
        wr_act    = wr_strobe && !r_q.wr_seen;
        r_d.wr_seen = wr_strobe;
        op        = din[DATA_W-1 -: OP_W];
        eoi_act   = wr_act && !a0 && (op == OP_EOI);

        if (wr_act && a0) begin
            r_d.mask = din[LINES-1:0];
        end
        if (wr_act && !a0) begin
            case (op)
                OP_BASE:  r_d.base   = din[BASE_W-1:0];
                OP_IDENT: r_d.ident  = din[LVL_W-1:0];
                OP_RDSEL: r_d.rd_isr = din[0];
                OP_CASMAP: begin
                    if (din[HALF]) r_d.cmap[LINES-1:HALF] = din[HALF-1:0];
                    else           r_d.cmap[HALF-1:0]     = din[HALF-1:0];
                end
                default: ;
            endcase
        end

        if (eoi_act && isr_any) r_d.isr[isr_idx] = 1'b0;
        if (commit) begin
            r_d.isr[ack_lvl] = 1'b1;
            r_d.irr[ack_lvl] = 1'b0;
        end
        r_d.irr = r_d.irr | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // outputs
    always_comb begin
        map_hit = r_q.cmap[ack_lvl];
        cas_oe  = ms_sel && in_ack && ack_valid && map_hit;
        cas_out = cas_oe ? ack_lvl : '0;
        vec_en  = second && ack_matched && !(ms_sel && ack_valid && map_hit);
        rd_en   = !cs_n && !rd_n;
        rd_data = '0;
        if (a0)             rd_data[LINES-1:0] = r_q.mask;
        else if (r_q.rd_isr) rd_data[LINES-1:0] = r_q.isr;
        else                rd_data[LINES-1:0] = r_q.irr;
        if (vec_en)     dout = {r_q.base, ack_lvl};
        else if (rd_en) dout = rd_data;
        else            dout = '0;
        dout_en = vec_en || rd_en;
        int_out = int_req;
    end

    AST_ISR_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(r_q.isr) <= $countones($past(r_q.isr)) + 1); // R5

    AST_COMMIT_FROM_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> r_q.irr[ack_lvl]); // R5

    AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_act && isr_any && !commit) |=>
            ($countones(r_q.isr) + 1 == $countones($past(r_q.isr)))); // R7

    AST_SLAVE_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_sel |-> !cas_oe); // R9

endmodule

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] irq = 8'h00;
    logic       int_out;
    logic       inta_n = 1'b1;
    logic       ms_sel = 1'b1;
    logic [2:0] cas_in = 3'd0;
    logic [2:0] cas_out;
    logic       cas_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pic_ctrl i_pic_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .din(din), .dout(dout), .dout_en(dout_en), .irq(irq),
        .int_out(int_out), .inta_n(inta_n), .ms_sel(ms_sel),
        .cas_in(cas_in), .cas_out(cas_out), .cas_oe(cas_oe)
    );

    // behavioural reference state
    logic [7:0] m_irr, m_isr, m_mask, m_map, m_prev;
    logic [4:0] m_base;
    logic [2:0] m_id, m_lvl;
    logic       m_rdisr, m_strobe, m_val, m_match;
    int         m_st;

    function automatic int lowest(input logic [7:0] v);
        int r = 8;
        for (int i = 7; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic m_req();
        logic [7:0] pend = m_irr & ~m_mask;
        return (pend != 0) && (m_isr == 0 || lowest(pend) < lowest(m_isr));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [7:0] rise = irq & ~m_prev;
        logic strobe = !cs_n && !wr_n;
        logic wact = strobe && !m_strobe;
        logic req = m_req();
        int p = lowest(m_irr & ~m_mask);
        int s = lowest(m_isr);
        logic commit = 0;
        logic [7:0] isr_n = m_isr, irr_n = m_irr;
        m_prev = irq;
        m_strobe = strobe;
        case (m_st)
            0: if (!inta_n) begin m_st = 1; m_val = req; m_lvl = req ? 3'(p) : 3'd7; end
            1: if (inta_n) begin
                   m_st = 2; m_match = ms_sel || (cas_in == m_id);
                   commit = m_val && m_match;
               end
            2: if (!inta_n) m_st = 3;
            default: if (inta_n) m_st = 0;
        endcase
        if (wact && !a0 && din[7:5] == 3'b001 && m_isr != 0) isr_n[s] = 1'b0;
        if (commit) begin isr_n[m_lvl] = 1'b1; irr_n[m_lvl] = 1'b0; end
        irr_n = irr_n | rise;
        if (wact && a0) m_mask = din;
        if (wact && !a0) begin
            case (din[7:5])
                3'b111: m_base = din[4:0];
                3'b110: m_id = din[2:0];
                3'b010: m_rdisr = din[0];
                3'b101: if (din[4]) m_map[7:4] = din[3:0]; else m_map[3:0] = din[3:0];
                default: ;
            endcase
        end
        m_isr = isr_n;
        m_irr = irr_n;
    endtask

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_mask = 0; m_map = 0; m_prev = 0;
        m_base = 0; m_id = 0; m_lvl = 0; m_rdisr = 0; m_strobe = 0;
        m_val = 0; m_match = 0; m_st = 0;
    endtask

    task automatic model_compare();
        logic vec = (m_st == 3) && m_match && !(ms_sel && m_val && m_map[m_lvl]);
        logic rde = !cs_n && !rd_n;
        logic coe = ms_sel && (m_st != 0) && m_val && m_map[m_lvl];
        logic [7:0] d = 0;
        if (vec) d = {m_base, m_lvl};
        else if (rde) d = a0 ? m_mask : (m_rdisr ? m_isr : m_irr);
        chk("R4 int_out", int'(int_out), int'(m_req()));
        chk("R6 dout_en", int'(dout_en), int'(vec || rde));
        chk("R6 dout", int'(dout), int'(d));
        chk("R8 cas_oe", int'(cas_oe), int'(coe));
        chk("R8 cas_out", int'(cas_out), coe ? int'(m_lvl) : 0);
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
        #1;
        if (rst_n && !done) model_compare();
    end

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic addr, input logic [7:0] val, input int hold, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; a0 = addr; din = val;
        repeat (hold) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic addr, output logic [7:0] val);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = addr;
        @(posedge clk); #1;
        val = dout;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse(input int line);
        @(negedge clk); irq[line] = 1'b1;
        @(negedge clk); irq[line] = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack(input logic [2:0] code, output logic [7:0] vec, output logic en,
                       output logic coe, output logic [2:0] cval);
        @(negedge clk); cas_in = code; inta_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        coe = cas_oe; cval = cas_out;
        @(negedge clk); inta_n = 1'b1;
        repeat (2) @(negedge clk);
        inta_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        vec = dout; en = dout_en;
        @(negedge clk); inta_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_sel(input logic use_isr, output logic [7:0] val);
        wr(1'b0, {7'b0100000, use_isr}, 1, 1'b0);
        rd(1'b0, val);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic en, coe;
        logic [2:0] cv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 int_out", int'(int_out), 0);
        chk("R1 dout_en", int'(dout_en), 0);
        chk("R1 cas_oe", int'(cas_oe), 0);
        rd(1'b0, v); chk("R1 irr", int'(v), 0);
        rd(1'b1, v); chk("R1 mask", int'(v), 0);

        wr(1'b0, 8'hEA, 1, 1'b0);              // base 0x0A
        pulse(3); settle();
        chk("R4 int raised", int'(int_out), 1);
        rd(1'b0, v); chk("R2 irr", int'(v), 8'h08);

        wr(1'b1, 8'h28, 1, 1'b0); settle();
        chk("R3 masked int", int'(int_out), 0);
        pulse(5); settle();
        chk("R3 still low", int'(int_out), 0);
        rd(1'b0, v); chk("R2 captured masked", int'(v), 8'h28);
        rd(1'b1, v); chk("R3 mask readback", int'(v), 8'h28);
        wr(1'b1, 8'h00, 1, 1'b0); settle();
        chk("R3 unmask raises", int'(int_out), 1);

        ack(3'd0, v, en, coe, cv);
        chk("R6 vector", int'(v), 8'h53);
        chk("R6 vector enable", int'(en), 1);
        read_sel(1'b1, v); chk("R5 isr", int'(v), 8'h08);
        read_sel(1'b0, v); chk("R5 irr", int'(v), 8'h20);
        settle();
        chk("R4 lower held off", int'(int_out), 0);

        pulse(1); settle();
        chk("R4 nested raise", int'(int_out), 1);
        ack(3'd0, v, en, coe, cv);
        chk("R6 nested vector", int'(v), 8'h51);
        read_sel(1'b1, v); chk("R5 nested isr", int'(v), 8'h0A);

        wr(1'b0, 8'h20, 3, 1'b0);              // held strobe: one EOI only
        rd(1'b0, v); chk("R7 R10 eoi once", int'(v), 8'h08);
        settle(); chk("R4 still held", int'(int_out), 0);
        wr(1'b0, 8'h20, 1, 1'b0);
        rd(1'b0, v); chk("R7 eoi clears", int'(v), 8'h00);
        settle(); chk("R7 pending resumes", int'(int_out), 1);
        ack(3'd0, v, en, coe, cv);
        chk("R6 vector 5", int'(v), 8'h55);
        wr(1'b0, 8'h20, 1, 1'b0);

        wr(1'b1, 8'hFF, 1, 1'b1);              // cs high: ignored
        rd(1'b1, v); chk("R10 cs high ignored", int'(v), 8'h00);

        wr(1'b0, 8'hB4, 1, 1'b0);              // map line 6
        pulse(6);
        ack(3'd0, v, en, coe, cv);
        chk("R8 cas_oe", int'(coe), 1);
        chk("R8 cas_out", int'(cv), 6);
        chk("R8 no vector", int'(en), 0);
        wr(1'b0, 8'h20, 1, 1'b0);

        ms_sel = 1'b0;
        wr(1'b0, 8'hC2, 1, 1'b0);              // identity 2
        pulse(4);
        ack(3'd5, v, en, coe, cv);
        chk("R9 mismatch no vector", int'(en), 0);
        chk("R9 slave cas_oe", int'(coe), 0);
        read_sel(1'b0, v); chk("R9 irr kept", int'(v), 8'h10);
        ack(3'd2, v, en, coe, cv);
        chk("R9 match vector", int'(v), 8'h54);
        chk("R9 match enable", int'(en), 1);
        read_sel(1'b1, v); chk("R9 isr", int'(v), 8'h10);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule